// File: doc/BRIEF.md
# Destructive-Read Word Memory with Access Sequencer

This block is a small word-addressed storage array fronted by a control unit that runs exactly one access cycle per request. The array behaves like storage whose read operation wipes the sensed cell to zero. The control unit hides that from the user. On a read it captures the word in an information register and writes it back, so the cell keeps its contents. On a write it clears the cell before storing the new word.

A client raises `req_i` for one clock, together with an address, a read/write operation code and, for writes, a data word. The sequencer samples all of these on that edge. It then steps through decode, sense or clear, restore or store, and a completion phase. It raises `done_o` for one clock at the end of the cycle. `busy_o` is high from the cycle after the request until completion. Any request seen while busy is dropped. Read data stays on `rdata_o` until the next read completes.

Top module: `dr_mem_seq`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `rdata_o` is all zeros.
- R2: With `req_i` held low the block stays idle: `busy_o` remains 0 and `done_o` never rises.
- R3: Address, operation code (`op_wr_i`, 1 = write, 0 = read) and write data are sampled on the rising edge where `req_i` is 1 while idle. Later changes on those inputs do not affect the running cycle.
- R4: A read returns on `rdata_o` the word most recently written to that address.
- R5: A read restores the sensed word into the cell, so a second read of the same address returns the same word.
- R6: A write fully replaces the old cell contents. The cell is cleared before the store, so no bit of the old word survives.
- R7: A write transfers nothing from the array toward the output: `rdata_o` keeps the value of the last completed read through a write cycle.
- R8: `done_o` is high for exactly one clock, in the fourth clock after the sampling edge. `busy_o` is 1 from the first to the fourth clock after that edge and 0 in the fifth.
- R9: A request asserted while `busy_o` is 1 is ignored and has no effect on the array.
- R10: Reset clears every cell of the array to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| op_wr_i | input | 1 | Operation: 1 write, 0 read |
| addr_i | input | AW | Cell address |
| wdata_i | input | WIDTH | Word to write |
| busy_o | output | 1 | Access cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | WIDTH | Word from the last completed read |

## Verification
The bench rereads a cell right after reading it. A sequencer that skipped the write-back would return zero the second time. It writes a sparse word over an all-ones word, which exposes a store that merges into the old contents instead of clearing first. It changes the address, operation and data buses right after the request edge, and fires a stray write request in the middle of a busy cycle. A design that sampled late or accepted requests while busy would then corrupt a cell that is later read back as zero. Each access is timed from the request edge to `done_o`, so a lost or extra phase shows up as the wrong latency. A write that sensed the array would also disturb the held read data.

// File: rtl/dr_mem_seq.sv
`timescale 1ns/1ps
module dr_mem_seq #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             op_wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] rdata_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_SENSE, S_CLEAR, S_RESTORE, S_STORE, S_DONE
  } phase_t;

  phase_t           state_q;
  logic [AW-1:0]    addr_q;
  logic             wr_q;
  logic [WIDTH-1:0] info_q;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] mem [DEPTH];

  wire start = (state_q == S_IDLE) && req_i;

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_DONE);
  assign rdata_o = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      info_q  <= '0;
      out_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          addr_q  <= addr_i;
          wr_q    <= op_wr_i;
          if (op_wr_i) info_q <= wdata_i;
          state_q <= S_DECODE;
        end
        S_DECODE:  state_q <= wr_q ? S_CLEAR : S_SENSE;
        S_SENSE: begin
          info_q  <= mem[addr_q];
          state_q <= S_RESTORE;
        end
        S_CLEAR:   state_q <= S_STORE;
        S_RESTORE: begin
          out_q   <= info_q;
          state_q <= S_DONE;
        end
        S_STORE:   state_q <= S_DONE;
        S_DONE:    state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      unique case (state_q)
        S_SENSE, S_CLEAR:   mem[addr_q] <= '0;
        S_RESTORE, S_STORE: mem[addr_q] <= info_q;
        default: ;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i) |=> busy_o); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(addr_q)); // R9
  AST_SENSE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SENSE) |=> (mem[$past(addr_q)] == '0)); // R5
  AST_RESTORE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RESTORE) |=> (mem[$past(addr_q)] == $past(info_q))); // R5
  AST_CLEAR_NO_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CLEAR) |=> ($stable(info_q) && mem[$past(addr_q)] == '0)); // R7
  AST_WRITE_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && wr_q && $past(busy_o)) |-> $stable(rdata_o)); // R7

endmodule

// File: tb/dr_mem_seq_tb.sv
`timescale 1ns/1ps
module dr_mem_seq_tb_top;
  localparam int DEPTH = 16, WIDTH = 8, AW = 4;
  localparam int NV = 12;
  // {op_wr, addr, data, expected rdata}
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'd3,  8'hA5, 8'h00},
    {1'b1, 4'd7,  8'h3C, 8'h00},
    {1'b0, 4'd3,  8'h00, 8'hA5},
    {1'b0, 4'd3,  8'h00, 8'hA5},
    {1'b1, 4'd3,  8'hFF, 8'hA5},
    {1'b1, 4'd3,  8'h0F, 8'hA5},
    {1'b0, 4'd3,  8'h00, 8'h0F},
    {1'b0, 4'd7,  8'h00, 8'h3C},
    {1'b0, 4'd0,  8'h00, 8'h00},
    {1'b1, 4'd15, 8'h81, 8'h00},
    {1'b0, 4'd15, 8'h00, 8'h81},
    {1'b0, 4'd15, 8'h00, 8'h81}
  };

  logic clk = 0, rst_n = 0, req = 0, op_wr = 0;
  logic [AW-1:0] addr = '0;
  logic [WIDTH-1:0] wdata = '0;
  logic busy, done;
  logic [WIDTH-1:0] rdata;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dr_mem_seq #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .op_wr_i(op_wr),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata));

  task automatic check(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a,
                        input logic [WIDTH-1:0] d, input bit stray,
                        output logic [WIDTH-1:0] got);
    int lat;
    @(negedge clk);
    req = 1; op_wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; op_wr = ~w; addr = ~a; wdata = ~d;  // R3 bus scrambled
    lat = 1;
    check("R8 busy", busy, 1);
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
      if (stray && lat == 2) begin req = 1; op_wr = 1; addr = 4'd9; wdata = 8'h77; end
      else req = 0;
    end
    req = 0;
    check("R8 latency", lat, 4);
    got = rdata;
    @(negedge clk);
    check("R8 done/busy drop", {done, busy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] got;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rdata", rdata, 0);
    rst_n = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R2 idle", {busy, done}, 0);
    end
    for (int v = 0; v < NV; v++) begin
      access(VEC[v][20], VEC[v][19:16], VEC[v][15:8], 1'b0, got);
      // R4 R5 R6 R7: rdata after every access
      check(VEC[v][20] ? "R7 rdata held" : "R4/R5/R6 read", got, VEC[v][7:0]);
    end
    // R9: stray write during a busy read must be dropped
    access(1'b0, 4'd7, 8'h00, 1'b1, got);
    check("R9 read during stray", got, 8'h3C);
    access(1'b0, 4'd9, 8'h00, 1'b0, got);
    check("R9 stray ignored", got, 8'h00);
    // R10: reset clears array
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    access(1'b0, 4'd3, 8'h00, 1'b0, got);
    check("R10 cell 3 cleared", got, 8'h00);
    access(1'b0, 4'd15, 8'h00, 1'b0, got);
    check("R10 cell 15 cleared", got, 8'h00);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule